// File: doc/BRIEF.md
# Error-Event Matched Filter Bank

This block scores six alternating error-event shapes against one recovered codeword that a partial-response detector has produced. Each codeword position arrives as one beat: the equalizer sample, the recovered bit, and a six-bit mask that says at which positions each event type may start. The block rebuilds the expected noiseless sample from the recovered bits and the channel target 1 + 6D + 7D² + 2D³. It subtracts that from the equalizer sample to get an error signal, and correlates the error signal with each event's target-filtered shape. A fixed half-energy offset is taken off each correlation.

For each event type the block keeps the largest offset-corrected score and the position where it occurred, over the masked positions only. After the last beat, the block feeds zero error samples through its window so that events starting near the end of the codeword are scored too. It then pulses `done`, and the six results stay on the outputs until the next codeword starts. Choosing which event to correct is left to the logic downstream.

The input is a valid/ready stream:
- A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- The source may leave gaps by holding `in_valid` low.
- `in_ready` falls after the beat flagged `in_last` is taken, and rises again once `done` has pulsed.
- A codeword may hold at most `MAX_LEN` beats.

Top module: `event_mf_bank`

## Requirements
- R1: The error sample for position k is q_k minus the sum g_0·b_k + g_1·b_(k-1) + g_2·b_(k-2) + g_3·b_(k-3). The taps are g = (1, 6, 7, 2). Bit value 1 counts as +1 and bit value 0 counts as −1. Positions before the first beat of the codeword contribute 0.
- R2: Event type t (t = 0..5, bit t of `in_mask`) has length t+2 and amplitudes +2, −2, +2, … beginning with +2. Its filter h_t is that event convolved with g, giving t+5 taps.
- R3: The score of type t at start position i is the sum over m of e_(i+m)·h_t[m], minus K_t, where K_t is half the sum of h_t[m]². Error samples past the last beat count as 0.
- R4: For each type t, `out_score` slice t is the largest score over the start positions i whose mask bit t was set on beat i. `out_pos` slice t is that i, with the first beat of the codeword being position 0.
- R5: When several masked positions give the same largest score, the lowest position is reported.
- R6: If a type's mask bit is never set in a codeword, that type's `out_ok` bit is 0 and its score and position slices are 0. Otherwise `out_ok` is 1.
- R7: A beat is taken only on an edge with `in_valid` and `in_ready` both high. Cycles with `in_valid` low change nothing. `in_ready` is low from the edge after the `in_last` beat is taken until `done` has pulsed.
- R8: `done` is high for exactly one cycle, beginning 10 rising edges after the edge that took the `in_last` beat. The results are final in that cycle and are held until the first beat of the next codeword is taken.
- R9: After reset, `in_ready` is 1, `done` is 0, and all `out_ok`, `out_score` and `out_pos` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be taken |
| in_last | input | 1 | Final beat of the codeword |
| in_q | input | QW | Signed equalizer sample |
| in_bit | input | 1 | Recovered bit (1 → +1, 0 → −1) |
| in_mask | input | 6 | Allowed-start flags, one per event type |
| done | output | 1 | One-cycle end-of-scan pulse |
| out_ok | output | 6 | Per-type result present |
| out_score | output | 6·(QW+14) | Signed best score per type, type t at bits t·(QW+14) upward |
| out_pos | output | 6·PW | Best start position per type, PW = clog2(MAX_LEN+11) |

## Verification
The bench builds the block with QW = 10 and MAX_LEN = 64. This keeps the position counter at 7 bits, so codewords can run to the full buffer length and reach every end-of-codeword position in short runs. The 10-bit samples still leave room for injected events plus noise without clipping. With these values the bench can cover a one-beat codeword, codewords shorter than the 10-tap longest filter, fully masked noiseless codewords where every score ties, and a 64-beat codeword that fills the counter range.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

  localparam int TAPS   = 4;
  localparam int NTYPES = 6;
  localparam int EV_MIN = 2;
  localparam int EV_MAX = EV_MIN + NTYPES - 1;
  localparam int HMAX   = EV_MAX + TAPS - 1;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } mfb_state_e;

  // channel target taps, index = delay
  function automatic int tap(input int l);
    case (l)
      0:       return 1;
      1:       return 6;
      2:       return 7;
      3:       return 2;
      default: return 0;
    endcase
  endfunction

  // amplitude m of event type t, alternating from +2
  function automatic int ev_amp(input int t, input int m);
    if (m < 0 || m >= EV_MIN + t) return 0;
    return (m % 2 == 0) ? 2 : -2;
  endfunction

  // filtered event tap m for type t
  function automatic int htap(input int t, input int m);
    int s;
    s = 0;
    for (int l = 0; l < TAPS; l++) s += tap(l) * ev_amp(t, m - l);
    return s;
  endfunction

  // half energy of the filtered event
  function automatic int hoff(input int t);
    int s;
    s = 0;
    for (int m = 0; m < HMAX; m++) s += htap(t, m) * htap(t, m);
    return s / 2;
  endfunction

endpackage

// File: rtl/mfb_error_gen.sv
module mfb_error_gen
  import mfb_pkg::*;
#(
  parameter int QW = 12,
  parameter int EW = QW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  logic                 fill,
  input  logic signed [QW-1:0] q,
  input  logic                 dbit,
  output logic signed [EW-1:0] e_o
);

  localparam int HIST = TAPS - 1;

  logic signed [1:0] hist [HIST];
  int                yi;
  int                cur;

  always_comb begin
    cur = dbit ? 1 : -1;
    yi  = tap(0) * cur;
    for (int l = 1; l < TAPS; l++) yi += tap(l) * int'(hist[l-1]);
  end

  assign e_o = fill ? '0 : (EW'(q) - EW'(yi));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int l = 0; l < HIST; l++) hist[l] <= '0;
    end else if (adv && !fill) begin
      hist[0] <= dbit ? 2'sd1 : -2'sd1;
      for (int l = 1; l < HIST; l++) hist[l] <= hist[l-1];
    end
  end

endmodule

// File: rtl/mfb_window.sv
module mfb_window
  import mfb_pkg::*;
#(
  parameter int EW = 14,
  parameter int NT = NTYPES,
  parameter int HM = HMAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic signed [EW-1:0] e_in,
  input  logic [NT-1:0]        m_in,
  output logic signed [EW-1:0] win_o [HM],
  output logic [NT-1:0]        msk_o
);

  logic signed [EW-1:0] win [HM];
  logic [NT-1:0]        msk [HM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HM; i++) begin
        win[i] <= '0;
        msk[i] <= '0;
      end
    end else if (adv) begin
      win[0] <= e_in;
      msk[0] <= m_in;
      for (int i = 1; i < HM; i++) begin
        win[i] <= win[i-1];
        msk[i] <= msk[i-1];
      end
    end
  end

  assign win_o = win;
  assign msk_o = msk[HM-1];

endmodule

// File: rtl/mfb_score_unit.sv
module mfb_score_unit
  import mfb_pkg::*;
#(
  parameter int TYPE = 0,
  parameter int EW   = 14,
  parameter int SW   = 26,
  parameter int PW   = 13,
  parameter int HM   = HMAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 ev,
  input  logic                 sel,
  input  logic [PW-1:0]        pos,
  input  logic signed [EW-1:0] win [HM],
  output logic signed [SW-1:0] best_score,
  output logic [PW-1:0]        best_pos,
  output logic                 ok
);

  localparam int HL  = EV_MIN + TYPE + TAPS - 1;
  localparam int OFF = hoff(TYPE);

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] score;

  // oldest window slot holds the start sample
  always_comb begin
    acc = '0;
    for (int m = 0; m < HL; m++)
      acc = acc + SW'(win[HM-1-m]) * SW'(htap(TYPE, m));
  end

  assign score = acc - SW'(OFF);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      best_score <= '0;
      best_pos   <= '0;
      ok         <= 1'b0;
    end else if (ev && sel && (!ok || score > best_score)) begin
      best_score <= score;
      best_pos   <= pos;
      ok         <= 1'b1;
    end
  end

  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !clr) |=> (best_score >= $past(best_score)));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(ev && sel)) |=> ($stable(best_pos) && $stable(best_score) && $stable(ok)));

endmodule

// File: rtl/mfb_ctrl.sv
module mfb_ctrl
  import mfb_pkg::*;
#(
  parameter int PW = 13,
  parameter int HM = HMAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          adv,
  output logic          fill,
  output logic          first,
  output logic          hclr,
  output logic          ev,
  output logic [PW-1:0] pos,
  output logic          done
);

  localparam int FW = $clog2(HM);

  mfb_state_e    st;
  logic [PW-1:0] n;
  logic [FW-1:0] fcnt;
  logic          acc;

  assign in_ready = (st == ST_RUN);
  assign acc      = in_valid && in_ready;
  assign fill     = (st == ST_FLUSH);
  assign adv      = acc || fill;
  assign first    = acc && (n == '0);
  assign hclr     = (st == ST_DONE);
  assign done     = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      fcnt <= '0;
    end else begin
      case (st)
        ST_RUN: if (acc && in_last) begin
          st   <= ST_FLUSH;
          fcnt <= '0;
        end
        ST_FLUSH: begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == FW'(HM - 2)) st <= ST_DRAIN;
        end
        ST_DRAIN: st <= ST_DONE;
        default:  st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hclr) begin
      n   <= '0;
      ev  <= 1'b0;
      pos <= '0;
    end else begin
      ev <= adv && (n >= PW'(HM - 1));
      if (adv) begin
        n   <= n + 1'b1;
        pos <= n - PW'(HM - 1);
      end
    end
  end

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

endmodule

// File: rtl/event_mf_bank.sv
module event_mf_bank
  import mfb_pkg::*;
#(
  parameter int QW      = 12,
  parameter int MAX_LEN = 4096,
  localparam int NT     = NTYPES,
  localparam int SW     = QW + 14,
  localparam int PW     = $clog2(MAX_LEN + HMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic [QW-1:0]    in_q,
  input  logic             in_bit,
  input  logic [NT-1:0]    in_mask,
  output logic             done,
  output logic [NT-1:0]    out_ok,
  output logic [NT*SW-1:0] out_score,
  output logic [NT*PW-1:0] out_pos
);

  localparam int EW = QW + 2;

  logic                 adv, fill, first, hclr, ev;
  logic [PW-1:0]        pos;
  logic signed [EW-1:0] e_new;
  logic signed [EW-1:0] win [HMAX];
  logic [NT-1:0]        msk_old;
  logic [NT-1:0]        m_in;

  assign m_in = fill ? '0 : in_mask;

  mfb_ctrl #(.PW(PW), .HM(HMAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .adv(adv), .fill(fill), .first(first),
    .hclr(hclr), .ev(ev), .pos(pos), .done(done)
  );

  mfb_error_gen #(.QW(QW), .EW(EW)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(hclr), .adv(adv), .fill(fill),
    .q(signed'(in_q)), .dbit(in_bit), .e_o(e_new)
  );

  mfb_window #(.EW(EW), .NT(NT), .HM(HMAX)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .e_in(e_new), .m_in(m_in),
    .win_o(win), .msk_o(msk_old)
  );

  for (genvar t = 0; t < NT; t++) begin : g_type
    logic signed [SW-1:0] bs;
    logic [PW-1:0]        bp;
    logic                 bo;

    mfb_score_unit #(.TYPE(t), .EW(EW), .SW(SW), .PW(PW), .HM(HMAX)) u_su (
      .clk(clk), .rst_n(rst_n), .clr(first), .ev(ev), .sel(msk_old[t]),
      .pos(pos), .win(win), .best_score(bs), .best_pos(bp), .ok(bo)
    );

    assign out_score[t*SW +: SW] = bs;
    assign out_pos[t*PW +: PW]   = bp;
    assign out_ok[t]             = bo;
  end

endmodule

// File: tb/test_event_mf_bank.sv
module test_event_mf_bank;

  localparam int QW   = 10;
  localparam int MAXL = 64;
  localparam int NT   = 6;
  localparam int HM   = 10;
  localparam int SW   = QW + 14;
  localparam int PW   = $clog2(MAXL + HM + 1);
  localparam int NV   = 9;

  // len, seed, density(0..4), kill bits, mode(0 clean,1 event+noise,2 clean late mask), gaps
  localparam int TV [NV][6] = '{
    '{40, 11, 2, 0,  1, 0},
    '{64, 23, 1, 8,  1, 1},
    '{1,  5,  4, 0,  1, 0},
    '{25, 77, 4, 0,  0, 0},
    '{12, 9,  3, 33, 1, 1},
    '{33, 41, 0, 0,  1, 0},
    '{9,  3,  4, 0,  1, 1},
    '{50, 99, 1, 0,  1, 1},
    '{20, 61, 4, 0,  2, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_last = 1'b0;
  logic [QW-1:0]    in_q = '0;
  logic             in_bit = 1'b0;
  logic [NT-1:0]    in_mask = '0;
  logic             done;
  logic [NT-1:0]    out_ok;
  logic [NT*SW-1:0] out_score;
  logic [NT*PW-1:0] out_pos;

  event_mf_bank #(.QW(QW), .MAX_LEN(MAXL)) i_event_mf_bank (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_q(in_q), .in_bit(in_bit), .in_mask(in_mask),
    .done(done), .out_ok(out_ok), .out_score(out_score), .out_pos(out_pos)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  int unsigned rs;
  int          fq [MAXL];
  bit          fb [MAXL];
  logic [NT-1:0] fm [MAXL];
  int          g [4] = '{1, 6, 7, 2};
  int          h [NT][HM];
  longint      kof [NT];
  longint      x_sc [NT];
  int          x_pos [NT];
  bit          x_ok [NT];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nr();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  // R2: filtered event shapes and half-energy offsets
  task automatic make_filters();
    for (int t = 0; t < NT; t++) begin
      kof[t] = 0;
      for (int m = 0; m < HM; m++) begin
        h[t][m] = 0;
        for (int l = 0; l < 4; l++)
          if (m - l >= 0 && m - l < t + 2) h[t][m] += g[l] * (((m - l) % 2 == 0) ? 2 : -2);
        kof[t] += h[t][m] * h[t][m];
      end
      kof[t] = kof[t] / 2;
    end
  endtask

  task automatic build(input int len, input int seed, input int dens, input int kill, input int mode);
    int at [MAXL];
    rs = seed * 7919 + 1;
    for (int i = 0; i < len; i++) begin
      fb[i] = nr() % 2;
      for (int t = 0; t < NT; t++)
        fm[i][t] = ((nr() % 4) < dens) && !kill[t];
      if (mode == 2) fm[i] = (i >= 5 && i % 2 == 1) ? NT'(~kill) : '0;
      at[i] = fb[i] ? 1 : -1;
    end
    if (mode == 1) begin
      int t0, p0;
      t0 = nr() % 6;
      p0 = nr() % len;
      for (int m = 0; m < t0 + 2; m++)
        if (p0 + m < len) begin
          fb[p0+m] = (m % 2 == 1);
          at[p0+m] = fb[p0+m] ? -1 : 1;
        end
    end
    for (int k = 0; k < len; k++) begin
      fq[k] = 0;
      for (int l = 0; l < 4; l++) if (k - l >= 0) fq[k] += g[l] * at[k-l];
      if (mode == 1) fq[k] += int'(nr() % 7) - 3;
    end
  endtask

  // R1 R3 R4 R5 R6 reference
  task automatic reference(input int len);
    int e [MAXL+HM];
    for (int k = 0; k < MAXL + HM; k++) begin
      e[k] = 0;
      if (k < len) begin
        e[k] = fq[k];
        for (int l = 0; l < 4; l++) if (k - l >= 0) e[k] -= g[l] * (fb[k-l] ? 1 : -1);
      end
    end
    for (int t = 0; t < NT; t++) begin
      x_ok[t] = 0; x_sc[t] = 0; x_pos[t] = 0;
      for (int i = 0; i < len; i++) if (fm[i][t]) begin
        longint s;
        s = -kof[t];
        for (int m = 0; m < t + 5; m++) s += longint'(e[i+m]) * h[t][m];
        if (!x_ok[t] || s > x_sc[t]) begin
          x_ok[t] = 1; x_sc[t] = s; x_pos[t] = i;
        end
      end
    end
  endtask

  task automatic compare(input int v);
    for (int t = 0; t < NT; t++) begin
      chk("R4 R6", $sformatf("vec %0d type %0d ok", v, t), out_ok[t], x_ok[t]);
      chk("R1 R2 R3 R4", $sformatf("vec %0d type %0d score", v, t),
          longint'($signed(out_score[t*SW +: SW])), x_sc[t]);
      chk("R4 R5", $sformatf("vec %0d type %0d pos", v, t), out_pos[t*PW +: PW], x_pos[t]);
    end
  endtask

  task automatic drive(input int len, input int gaps, input int v);
    int cnt;
    logic [NT*SW-1:0] sc_hold;
    for (int k = 0; k < len; k++) begin
      if (gaps != 0 && nr() % 3 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_q = QW'(nr());
        in_bit = nr() % 2;
        in_mask = '1;
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_q     = QW'(fq[k]);
      in_bit   = fb[k];
      in_mask  = fm[k];
      in_last  = (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_mask  = '1;
    chk("R7", $sformatf("vec %0d ready after last", v), in_ready, 0);
    cnt = 0;
    while (cnt < 40) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
    end
    chk("R8", $sformatf("vec %0d edges to done", v), cnt, HM);
    compare(v);
    sc_hold = out_score;
    @(negedge clk);
    chk("R8", $sformatf("vec %0d done width", v), done, 0);
    chk("R7", $sformatf("vec %0d ready back", v), in_ready, 1);
    chk("R8", $sformatf("vec %0d results held", v), (out_score == sc_hold), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R8 watchdog: actual %0d cycles expected completion", 200000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    make_filters();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "ready", in_ready, 1);
    chk("R9", "done", done, 0);
    chk("R9", "ok", out_ok, 0);
    chk("R9", "score bits", (out_score == '0), 1);
    chk("R9", "pos bits", (out_pos == '0), 1);

    for (int v = 0; v < NV; v++) begin
      build(TV[v][0], TV[v][1], TV[v][2], TV[v][3], TV[v][4]);
      reference(TV[v][0]);
      drive(TV[v][0], TV[v][5], v);
    end

    // R5: clean codeword, all masked, every score equals -K at position 0
    build(30, 5, 4, 0, 0);
    reference(30);
    drive(30, 1, 100);
    for (int t = 0; t < NT; t++) begin
      chk("R5", $sformatf("tie type %0d pos", t), out_pos[t*PW +: PW], 0);
      chk("R3", $sformatf("tie type %0d offset", t),
          longint'($signed(out_score[t*SW +: SW])), -kof[t]);
    end

    // R7: idle cycles between codewords leave results untouched
    begin
      logic [NT*SW-1:0] keep;
      keep = out_score;
      @(negedge clk);
      in_valid = 1'b0;
      in_q = '1;
      repeat (5) @(negedge clk);
      chk("R7", "idle hold score", (out_score == keep), 1);
      chk("R7", "idle no done", done, 0);
    end

    // R6: second codeword after a full one clears a type with no mask
    build(15, 8, 4, 4, 1);
    reference(15);
    drive(15, 0, 101);
    chk("R6", "killed type ok", out_ok[2], 0);
    chk("R6", "killed type score", (out_score[2*SW +: SW] == '0), 1);
    chk("R6", "killed type pos", out_pos[2*PW +: PW], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule